// File: doc/BRIEF.md
# Synchronous Strobe-Bus Transaction Master

This block runs single write and read transfers on a simple parallel bus that uses active-low select and strobe lines. A user-side agent hands it one command at a time through a valid/ready request port. Each command carries a direction bit, an address and write data. The master then drives the bus strobes on a fixed clock schedule. It holds the address, and the write data, steady while select is asserted. It reports completion with a single-cycle done pulse and returns read data on a held output.

Writes assert select one clock before the write strobe. The write strobe is then held low for a fixed number of clocks, and select stays low one clock longer than the strobe. Reads assert select and the read strobe together for a fixed number of clocks. The read data is captured on the edge where both lines return high. Every transfer is followed by a short idle gap, and no new command is accepted during that gap. The strobe lengths and the gap length are parameters. Their defaults are a 3-clock write strobe, a 9-clock read window and a 2-clock gap.

Top module: `bus_strobe_master`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release: `bus_cs_n`, `bus_we_n` and `bus_re_n` are 1; `bus_addr`, `bus_wdata` and `rsp_rdata` are 0; `rsp_done` is 0; and `req_ready` is 1.
- R2: `req_ready` is 1 only when the master is idle. A command is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_write` = 1 selects a write and 0 selects a read. In the cycle after acceptance `bus_cs_n` is 0 and `bus_addr` equals the accepted `req_addr`.
- R3: Write: in cycle 1 after acceptance, `bus_cs_n` is 0 and `bus_we_n` is 1. `bus_we_n` is then 0 for exactly cycles 2 to 4.
- R4: Write: `bus_cs_n` stays 0 in cycle 5, the first cycle after `bus_we_n` returns to 1, and is 1 from cycle 6.
- R5: Read: `bus_cs_n` and `bus_re_n` both go to 0 in cycle 1 after acceptance, stay 0 through cycle 9, and both return to 1 in cycle 10.
- R6: `rsp_rdata` takes the value `bus_rdata` had just before the edge that ends read cycle 9. It is visible from cycle 10 and is unchanged by writes and by idle time until the next read completes.
- R7: `bus_addr` and `bus_wdata` do not change while `bus_cs_n` is 0. `bus_wdata` is loaded only by an accepted write, so a read leaves it unchanged.
- R8: `bus_re_n` stays 1 throughout a write, and `bus_we_n` stays 1 throughout a read. The two strobes are never 0 together.
- R9: `rsp_done` is 1 for exactly one cycle per transfer. That cycle is the first one with `bus_cs_n` back at 1: cycle 6 for writes and cycle 10 for reads.
- R10: After `bus_cs_n` returns to 1, `req_ready` stays 0 for two cycles, and `req_valid` is ignored during them. `req_ready` is 1 again in cycle 8 of a write and cycle 12 of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Master idle and able to accept a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Command address |
| req_wdata | input | 32 | Command write data |
| rsp_done | output | 1 | One-cycle pulse at the end of each transfer |
| rsp_rdata | output | 32 | Data of the most recent completed read |
| bus_cs_n | output | 1 | Bus select, active low |
| bus_we_n | output | 1 | Bus write strobe, active low |
| bus_re_n | output | 1 | Bus read strobe, active low |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data from the slave |

## Verification
The assertions assume that `req_valid`, `req_write` and the request fields are known (never X) at every rising edge after reset. They make no assumption about `bus_rdata`, because the master only samples it. The stimulus changes every input at the falling edge. It keeps `req_valid` high with random junk on the request fields throughout each transfer and its gap, so that any command taken while busy would show up on the bus. It also moves `bus_rdata` to a fresh random value every cycle except the one just before the capture edge.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_W_LEAD = 3'd1,
    ST_W_STRB = 3'd2,
    ST_W_TAIL = 3'd3,
    ST_R_ACT  = 3'd4,
    ST_GAP    = 3'd5
  } seq_state_e;

  function automatic logic sel_active(input seq_state_e s);
    return (s == ST_W_LEAD) || (s == ST_W_STRB) ||
           (s == ST_W_TAIL) || (s == ST_R_ACT);
  endfunction

endpackage

// File: rtl/bsm_phase_timer.sv
module bsm_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/bsm_sequencer.sv
module bsm_sequencer
  import bsm_pkg::*;
#(
  parameter int WR_PULSE = 3,
  parameter int RD_PULSE = 9,
  parameter int GAP_CYC  = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             rd_capture,
  output logic             cs_n,
  output logic             we_n,
  output logic             re_n,
  output logic             done
);

  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_PULSE - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       cs_n_q, we_n_q, re_n_q, done_q;
  logic       cs_n_d, we_n_d, re_n_d, done_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // next-state and timer control
  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d = ST_W_LEAD;
          end else begin
            state_d  = ST_R_ACT;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_W_LEAD: begin
        state_d  = ST_W_STRB;
        tmr_load = 1'b1;
        tmr_val  = WR_LOAD;
      end
      ST_W_STRB: begin
        if (tmr_zero) state_d = ST_W_TAIL;
      end
      ST_W_TAIL: begin
        state_d  = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = GAP_LOAD;
        done_d   = 1'b1;
      end
      ST_R_ACT: begin
        if (tmr_zero) begin
          state_d    = ST_GAP;
          tmr_load   = 1'b1;
          tmr_val    = GAP_LOAD;
          rd_capture = 1'b1;
          done_d     = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes are registered from the next state so the pins never glitch
  always_comb begin
    cs_n_d = !sel_active(state_d);
    we_n_d = (state_d != ST_W_STRB);
    re_n_d = (state_d != ST_R_ACT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      re_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      re_n_q  <= re_n_d;
      done_q  <= done_d;
    end
  end

  assign cs_n = cs_n_q;
  assign we_n = we_n_q;
  assign re_n = re_n_q;
  assign done = done_q;

endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              addr_en, wdata_en, rdata_en;

  assign addr_en  = accept;
  assign wdata_en = accept && req_write;
  assign rdata_en = rd_capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= bus_rdata;
    end
  end

  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/bus_strobe_master.sv
module bus_strobe_master #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WR_PULSE = 3,
  parameter int RD_PULSE = 9,
  parameter int GAP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_re_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int MAX_A   = (WR_PULSE > RD_PULSE) ? WR_PULSE : RD_PULSE;
  localparam int MAX_CNT = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);

  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             rd_capture;

  bsm_sequencer #(
    .WR_PULSE (WR_PULSE),
    .RD_PULSE (RD_PULSE),
    .GAP_CYC  (GAP_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_zero   (tmr_zero),
    .req_ready  (req_ready),
    .accept     (accept),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .rd_capture (rd_capture),
    .cs_n       (bus_cs_n),
    .we_n       (bus_we_n),
    .re_n       (bus_re_n),
    .done       (rsp_done)
  );

  bsm_phase_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  bsm_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .bus_rdata  (bus_rdata),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              bus_cs_n,
  input logic              bus_we_n,
  input logic              bus_re_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);

  // R2: ready only while the bus is idle
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_we_n && bus_re_n));

  // R2: an accepted command asserts select on the next cycle
  a_r2_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !bus_cs_n);

  // R3: the write strobe falls only after a cycle of select with strobe high
  a_r3_we_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_we_n) |-> $past(!bus_cs_n && bus_we_n));

  // R4: select outlives the write strobe by exactly one cycle
  a_r4_we_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> (!bus_cs_n ##1 bus_cs_n));

  // R5: read strobe and select move together
  a_r5_re_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_re_n) |-> $fell(bus_cs_n));
  a_r5_re_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_re_n) |-> $rose(bus_cs_n));

  // R7: address and write data hold while select is low
  a_r7_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$fell(bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  // R8: strobes only under select and never both
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_n || bus_re_n) && ((bus_we_n && bus_re_n) || !bus_cs_n));

  // R9: done is a single pulse coincident with select release
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($rose(bus_cs_n) ##1 !rsp_done));

  // R10: two idle cycles after select release
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (!req_ready ##1 !req_ready ##1 req_ready));

endmodule

bind bus_strobe_master bsm_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .bus_cs_n  (bus_cs_n),
  .bus_we_n  (bus_we_n),
  .bus_re_n  (bus_re_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_bus_strobe_master.sv
module tb_bus_strobe_master;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        bus_cs_n;
  logic        bus_we_n;
  logic        bus_re_n;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] exp_addr;
  logic [31:0] exp_wdata;
  logic [31:0] exp_rdata;

  bus_strobe_master dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_re_n  (bus_re_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected schedule, cycle c counted from the accepting edge
  function automatic logic f_cs_n(input bit w, input int c);
    return w ? !(c >= 1 && c <= 5) : !(c >= 1 && c <= 9);
  endfunction
  function automatic logic f_we_n(input bit w, input int c);
    return w ? !(c >= 2 && c <= 4) : 1'b1;
  endfunction
  function automatic logic f_re_n(input bit w, input int c);
    return w ? 1'b1 : !(c >= 1 && c <= 9);
  endfunction
  function automatic logic f_done(input bit w, input int c);
    return (c == (w ? 6 : 10));
  endfunction
  function automatic logic f_ready(input bit w, input int c);
    return (c >= (w ? 8 : 12));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_cycles(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(bus_cs_n && bus_we_n && bus_re_n, "R2 idle strobes", {29'd0, bus_cs_n, bus_we_n, bus_re_n}, 32'd7);
      chk(req_ready == 1'b1, "R2 idle ready", {31'd0, req_ready}, 32'd1);
      chk(rsp_done == 1'b0, "R9 idle done", {31'd0, rsp_done}, 32'd0);
      chk(rsp_rdata == exp_rdata, "R6 idle hold", rsp_rdata, exp_rdata);
      bus_rdata = $urandom;
    end
  endtask

  // called at a falling edge with the master idle
  task automatic run_txn(input bit w, input logic [31:0] a, input logic [31:0] d,
                         input logic [31:0] rd_val);
    int last;
    string t_sel;
    chk(req_ready == 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_valid = 1'b1;
    @(posedge clk);
    exp_addr = a;
    if (w) exp_wdata = d;
    last = w ? 8 : 12;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      if (!w && c == 10) exp_rdata = rd_val;
      if (w) t_sel = (c <= 4) ? "R3 select" : "R4 select";
      else   t_sel = "R5 select";
      chk(bus_cs_n == f_cs_n(w, c), t_sel, {31'd0, bus_cs_n}, {31'd0, f_cs_n(w, c)});
      chk(bus_we_n == f_we_n(w, c), w ? "R3 write strobe" : "R8 write strobe in read",
          {31'd0, bus_we_n}, {31'd0, f_we_n(w, c)});
      chk(bus_re_n == f_re_n(w, c), w ? "R8 read strobe in write" : "R5 read strobe",
          {31'd0, bus_re_n}, {31'd0, f_re_n(w, c)});
      chk(rsp_done == f_done(w, c), "R9 done", {31'd0, rsp_done}, {31'd0, f_done(w, c)});
      chk(req_ready == f_ready(w, c), "R10 ready", {31'd0, req_ready}, {31'd0, f_ready(w, c)});
      chk(bus_addr == exp_addr, "R7 address", bus_addr, exp_addr);
      chk(bus_wdata == exp_wdata, "R7 write data", bus_wdata, exp_wdata);
      chk(rsp_rdata == exp_rdata, "R6 read data", rsp_rdata, exp_rdata);
      // junk command held valid while busy; dropped on the ready cycle
      req_addr  = $urandom;
      req_wdata = $urandom;
      req_write = 1'($urandom);
      req_valid = (c < last);
      bus_rdata = (!w && c == 9) ? rd_val : $urandom;
    end
  endtask

  initial begin
    bit done_flag;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; bus_rdata = 32'hFFFF_0000;
    exp_addr = '0; exp_wdata = '0; exp_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_we_n && bus_re_n, "R1 strobes", {29'd0, bus_cs_n, bus_we_n, bus_re_n}, 32'd7);
    chk(bus_addr == 32'd0, "R1 address", bus_addr, 32'd0);
    chk(bus_wdata == 32'd0, "R1 write data", bus_wdata, 32'd0);
    chk(rsp_rdata == 32'd0, "R1 read data", rsp_rdata, 32'd0);
    chk(rsp_done == 1'b0, "R1 done", {31'd0, rsp_done}, 32'd0);
    chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_we_n && bus_re_n, "R1 strobes after release", {29'd0, bus_cs_n, bus_we_n, bus_re_n}, 32'd7);

    // directed corner cases
    run_txn(1'b1, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h0);
    run_txn(1'b0, 32'h0000_0000, 32'h1111_1111, 32'hDEAD_BEEF);   // R7: read keeps write data
    run_txn(1'b0, 32'h1234_5678, 32'h0, 32'h0000_0000);           // back-to-back reads
    run_txn(1'b1, 32'h0000_0004, 32'h0000_0000, 32'h0);           // R6: write keeps read data
    idle_cycles(3);
    run_txn(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0);
    run_txn(1'b1, 32'h7FFF_FFFC, 32'h0F0F_0F0F, 32'h0);           // back-to-back writes

    // constrained random
    for (int k = 0; k < 80; k++) begin
      bit w;
      w = 1'($urandom);
      run_txn(w, $urandom, $urandom, $urandom);
      if (($urandom % 4) == 0) idle_cycles(1 + ($urandom % 3));
    end

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule